// File: doc/BRIEF.md
# Thread Block Dispatcher

This block accepts a launch of a grid of thread blocks and hands the blocks, one at a time, to a set of compute units. Each unit has a fixed budget of registers and shared memory. A grid carries one per-block cost in both resources, so a unit holds as many blocks at once as its remaining budget allows. A block stays on the unit it was given until that unit reports it finished. Blocks that fit nowhere stay pending inside the dispatcher. They go out as soon as a completion frees enough room.

The dispatcher does its own capacity accounting. Each unit has a ledger of free registers, free shared memory and resident blocks. The ledger is charged on every dispatch handshake and credited on every completion pulse from that unit. A credit can be spent by a placement in the cycle it arrives. Placement always picks the lowest-numbered unit that can take the next block. The unit count is a parameter, so the same grid runs on any configuration.

The control is a four-state machine:
- `ST_IDLE` is the state after reset.
- `ST_ISSUE` is the state while blocks remain to be handed out.
- `ST_DRAIN` is the state after all blocks have gone out, while some are still running.
- `ST_DONE` is the state after the grid has finished.

The transitions are:
- idle/done to issue: a launch with a nonzero count is accepted.
- idle/done to done: a launch with a zero count is accepted.
- issue to drain: the handshake of the last block.
- drain to done: the cycle in which the last outstanding block completes.

Top module: `blk_dispatcher`

## Requirements
- R1: `launch_ready` is high exactly in the idle and done states. A launch is taken only on a cycle with `launch_valid` and `launch_ready` both high. A launch presented while a grid is in flight is ignored. `launch_ready` and `disp_valid` are never high together.
- R2: Block indices go out in increasing order from 0 to count-1, one per handshake (`disp_valid` and `disp_ready` both high). While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and `disp_index` holds.
- R3: `disp_unit` is the lowest-numbered unit whose free registers and free shared memory, after this cycle's completion credits, are each at least the grid's per-block cost. The comparison is greater-or-equal, so an exact fit qualifies.
- R4: When no unit qualifies, `disp_valid` is low and the remaining blocks stay pending.
- R5: A completion pulse on unit u returns one block's cost to u. A block may be placed on u in that same cycle.
- R6: A unit's charged resources never exceed its capacity. A unit holds several blocks when their combined cost fits.
- R7: A completion pulse on a unit with no resident block is ignored. It adds no capacity and does not count toward grid completion.
- R8: `grid_done` rises the cycle after the last outstanding block completes. After a zero-count launch, it rises the cycle after acceptance. It stays high until the next launch is accepted.
- R9: After reset, `launch_ready` is 1, and `disp_valid` and `grid_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Dispatcher can take a launch |
| launch_count | input | CNT_W | Number of blocks in the grid |
| launch_regs | input | REG_W | Registers needed by each block |
| launch_smem | input | SMEM_W | Shared memory needed by each block |
| disp_valid | output | 1 | A block is offered for dispatch |
| disp_ready | input | 1 | Downstream takes the offered block |
| disp_index | output | CNT_W | Index of the offered block |
| disp_unit | output | UID_W | Target unit of the offered block |
| cmpl_pulse | input | NUM_UNITS | One bit per unit: a block on that unit finished |
| grid_done | output | 1 | All blocks dispatched and completed |

## Verification
A ledger that drifts from the true resident set shows up at the ports within a cycle. It appears as a `disp_unit` that skips a unit with room, a `disp_valid` that stays low while room exists, or a placement beyond capacity. A wrong outstanding count shows up either as `grid_done` rising while a block still runs, or as `grid_done` never rising. The bench keeps a cycle-level ledger model of its own. It compares `disp_valid`, `disp_unit`, `disp_index`, `launch_ready` and `grid_done` every cycle, so a fault is reported in the cycle it first becomes visible.

// File: rtl/blkd_pkg.sv
package blkd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } grid_state_t;

endpackage

// File: rtl/unit_ledger.sv
module unit_ledger #(
    parameter int REG_W    = 12,
    parameter int SMEM_W   = 12,
    parameter int RES_W    = 11,
    parameter int CAP_REGS = 1024,
    parameter int CAP_SMEM = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cost_regs,
    input  logic [SMEM_W-1:0] cost_smem,
    input  logic              cmpl_in,
    input  logic              grant,
    output logic              fit,
    output logic              cmpl_ok
);
    localparam logic [REG_W-1:0]  CAP_R = CAP_REGS[REG_W-1:0];
    localparam logic [SMEM_W-1:0] CAP_S = CAP_SMEM[SMEM_W-1:0];

    logic [REG_W-1:0]  free_r;
    logic [SMEM_W-1:0] free_s;
    logic [RES_W-1:0]  resident;
    logic [REG_W:0]    eff_r, nxt_r;
    logic [SMEM_W:0]   eff_s, nxt_s;

    // A completion only counts when a block actually lives here
    assign cmpl_ok = cmpl_in && (resident != '0);

    always_comb begin
        eff_r = {1'b0, free_r} + (cmpl_ok ? {1'b0, cost_regs} : '0);
        eff_s = {1'b0, free_s} + (cmpl_ok ? {1'b0, cost_smem} : '0);
        fit   = (eff_r >= {1'b0, cost_regs}) && (eff_s >= {1'b0, cost_smem});
        nxt_r = grant ? (eff_r - {1'b0, cost_regs}) : eff_r;
        nxt_s = grant ? (eff_s - {1'b0, cost_smem}) : eff_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_r   <= CAP_R;
            free_s   <= CAP_S;
            resident <= '0;
        end else begin
            free_r <= nxt_r[REG_W-1:0];
            free_s <= nxt_s[SMEM_W-1:0];
            if (grant && !cmpl_ok)
                resident <= resident + 1'b1;
            else if (!grant && cmpl_ok)
                resident <= resident - 1'b1;
        end
    end

    AST_REGS_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        free_r <= CAP_R);  // R6
    AST_SMEM_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        free_s <= CAP_S);  // R6
    AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> fit);  // R3
    AST_STRAY_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_in && resident == '0 && !grant) |=> $stable(free_r) && $stable(free_s));  // R7

endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int N  = 4,
    parameter int UW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [UW-1:0] idx,
    output logic          any
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot = '0;
                onehot[i] = 1'b1;
                idx    = UW'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/grid_fsm.sv
module grid_fsm
    import blkd_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_valid,
    input  logic [CNT_W-1:0] launch_count,
    input  logic             disp_ready,
    input  logic             any_fit,
    input  logic [CNT_W-1:0] n_cmpl,
    output logic             launch_ready,
    output logic             accept,
    output logic             disp_valid,
    output logic             hs,
    output logic [CNT_W-1:0] disp_index,
    output logic             grid_done
);
    grid_state_t      st, st_nx;
    logic [CNT_W-1:0] next_idx, total, outstanding, out_nx;
    logic             last_blk;

    assign out_nx   = outstanding + {{(CNT_W-1){1'b0}}, hs} - n_cmpl;
    assign last_blk = (next_idx == total - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_DONE: if (launch_valid)
                st_nx = (launch_count == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (hs && last_blk) st_nx = ST_DRAIN;
            ST_DRAIN: if (out_nx == '0)   st_nx = ST_DONE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        launch_ready = 1'b0;
        disp_valid   = 1'b0;
        grid_done    = 1'b0;
        unique case (st)
            ST_IDLE:  launch_ready = 1'b1;
            ST_ISSUE: disp_valid   = any_fit;
            ST_DRAIN: ;
            ST_DONE: begin
                launch_ready = 1'b1;
                grid_done    = 1'b1;
            end
            default: ;
        endcase
        accept = launch_ready && launch_valid;
        hs     = disp_valid && disp_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_idx    <= '0;
            total       <= '0;
            outstanding <= '0;
        end else begin
            outstanding <= out_nx;
            if (accept) begin
                next_idx <= '0;
                total    <= launch_count;
            end else if (hs) begin
                next_idx <= next_idx + 1'b1;
            end
        end
    end

    assign disp_index = next_idx;

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ready |-> !disp_valid);  // R1
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_index));  // R2
    AST_INDEX_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> disp_index < total);  // R2
    AST_NO_OVERCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        n_cmpl <= outstanding);  // R7
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> outstanding == '0);  // R8

endmodule

// File: rtl/blk_dispatcher.sv
module blk_dispatcher #(
    parameter int NUM_UNITS = 4,
    parameter int CNT_W     = 10,
    parameter int REG_W     = 12,
    parameter int SMEM_W    = 12,
    parameter int CAP_REGS  = 1024,
    parameter int CAP_SMEM  = 1024,
    parameter int UID_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    output logic                 launch_ready,
    input  logic [CNT_W-1:0]     launch_count,
    input  logic [REG_W-1:0]     launch_regs,
    input  logic [SMEM_W-1:0]    launch_smem,
    output logic                 disp_valid,
    input  logic                 disp_ready,
    output logic [CNT_W-1:0]     disp_index,
    output logic [UID_W-1:0]     disp_unit,
    input  logic [NUM_UNITS-1:0] cmpl_pulse,
    output logic                 grid_done
);
    localparam int RES_W = CNT_W + 1;

    logic [REG_W-1:0]     cost_r;
    logic [SMEM_W-1:0]    cost_s;
    logic [NUM_UNITS-1:0] fit_vec, cmpl_ok, pick_oh, grant_vec;
    logic [CNT_W-1:0]     n_cmpl;
    logic                 any_fit, accept, hs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost_r <= '0;
            cost_s <= '0;
        end else if (accept) begin
            cost_r <= launch_regs;
            cost_s <= launch_smem;
        end
    end

    assign grant_vec = pick_oh & {NUM_UNITS{hs}};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_ledger #(
            .REG_W(REG_W), .SMEM_W(SMEM_W), .RES_W(RES_W),
            .CAP_REGS(CAP_REGS), .CAP_SMEM(CAP_SMEM)
        ) u_ledger (
            .clk(clk), .rst_n(rst_n),
            .cost_regs(cost_r), .cost_smem(cost_s),
            .cmpl_in(cmpl_pulse[u]), .grant(grant_vec[u]),
            .fit(fit_vec[u]), .cmpl_ok(cmpl_ok[u])
        );
    end

    always_comb begin
        n_cmpl = '0;
        for (int u = 0; u < NUM_UNITS; u++)
            n_cmpl = n_cmpl + {{(CNT_W-1){1'b0}}, cmpl_ok[u]};
    end

    lowest_pick #(.N(NUM_UNITS), .UW(UID_W)) u_pick (
        .req(fit_vec), .onehot(pick_oh), .idx(disp_unit), .any(any_fit)
    );

    grid_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_count(launch_count),
        .disp_ready(disp_ready), .any_fit(any_fit), .n_cmpl(n_cmpl),
        .launch_ready(launch_ready), .accept(accept),
        .disp_valid(disp_valid), .hs(hs),
        .disp_index(disp_index), .grid_done(grid_done)
    );

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));  // R3
    AST_COST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> $stable(cost_r) && $stable(cost_s));  // R1

endmodule

// File: tb/sim_blk_dispatcher.sv
module sim_blk_dispatcher;
    localparam int NU = 4, CW = 10, RW = 12, SW = 12, CAPR = 1024, CAPS = 1024;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          launch_valid = 1'b0, disp_ready = 1'b1;
    logic          launch_ready, disp_valid, grid_done;
    logic [CW-1:0] launch_count = '0;
    logic [RW-1:0] launch_regs = '0;
    logic [SW-1:0] launch_smem = '0;
    logic [CW-1:0] disp_index;
    logic [1:0]    disp_unit;
    logic [NU-1:0] cmpl_pulse = '0;

    always #10 clk = ~clk;

    blk_dispatcher u0 (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_ready(launch_ready),
        .launch_count(launch_count), .launch_regs(launch_regs), .launch_smem(launch_smem),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_index(disp_index), .disp_unit(disp_unit),
        .cmpl_pulse(cmpl_pulse), .grid_done(grid_done)
    );

    int nchk = 0, nfail = 0;
    int exp_q[$];
    int mfree_r[NU], mfree_s[NU], mres[NU];
    int mrem = 0, mout = 0, mcr = 0, mcs = 0;
    bit mbusy = 0, mdone = 0, finished = 0;
    int held_idx;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference ledger and scoreboard monitor
    int  er, es, eu;
    bit  okc, ev;
    always @(negedge clk) if (rst_n && !finished) begin
        eu = -1;
        for (int u = 0; u < NU; u++) begin
            okc = cmpl_pulse[u] && mres[u] > 0;
            er = mfree_r[u] + (okc ? mcr : 0);
            es = mfree_s[u] + (okc ? mcs : 0);
            if (eu < 0 && er >= mcr && es >= mcs) eu = u;
        end
        ev = mbusy && mrem > 0 && eu >= 0;
        chk(disp_valid == ev, "R4 disp_valid", disp_valid, ev);
        chk(launch_ready == !mbusy, "R1 launch_ready", launch_ready, !mbusy);
        chk(grid_done == mdone, "R8 grid_done", grid_done, mdone);
        if (ev && disp_valid && disp_ready) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected block", disp_index, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(disp_index == e, "R2 index", disp_index, e);
            end
            chk(disp_unit == eu, "R3 R6 unit", disp_unit, eu);
        end
        for (int u = 0; u < NU; u++) begin
            if (cmpl_pulse[u] && mres[u] > 0) begin
                mfree_r[u] += mcr; mfree_s[u] += mcs; mres[u]--; mout--;
            end
        end
        if (ev && disp_ready) begin
            mfree_r[eu] -= mcr; mfree_s[eu] -= mcs; mres[eu]++; mout++; mrem--;
        end
        if (mbusy && mrem == 0 && mout == 0) begin
            mbusy = 0; mdone = 1;
        end
        if (launch_valid && !mbusy) begin
            mdone = (launch_count == 0);
            mbusy = (launch_count != 0);
            mrem = launch_count; mout = 0;
            mcr = launch_regs; mcs = launch_smem;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic launch(input int n, input int cr, input int cs);
        for (int i = 0; i < n; i++) exp_q.push_back(i);
        launch_valid = 1'b1; launch_count = CW'(n);
        launch_regs = RW'(cr); launch_smem = SW'(cs);
        step(1);
        launch_valid = 1'b0;
    endtask

    task automatic pulse(input int u);
        cmpl_pulse = NU'(1) << u;
        step(1);
        cmpl_pulse = '0;
    endtask

    task automatic until_issued();
        for (int k = 0; k < 200 && mrem > 0; k++) step(1);
    endtask

    task automatic until_done();
        for (int k = 0; k < 200 && !grid_done; k++) step(1);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) begin
            mfree_r[u] = CAPR; mfree_s[u] = CAPS; mres[u] = 0;
        end
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(launch_ready == 1, "R9 reset ready", launch_ready, 1);
        chk(disp_valid == 0, "R9 reset valid", disp_valid, 0);
        chk(grid_done == 0, "R9 reset done", grid_done, 0);
        step(1);

        // Several blocks per unit, register-limited (R6)
        launch(6, 400, 100);
        until_issued();
        pulse(0); pulse(0); pulse(1); pulse(1); pulse(2); pulse(2);
        @(negedge clk);
        chk(grid_done == 1, "R8 done after last completion", grid_done, 1);
        step(1);

        // Stray completion on an empty unit (R7)
        launch(1, 8, 8);
        until_issued();
        pulse(3);
        step(2);
        @(negedge clk);
        chk(grid_done == 0, "R7 stray completion ignored", grid_done, 0);
        step(1);
        pulse(0);
        @(negedge clk);
        chk(grid_done == 1, "R8 done", grid_done, 1);
        step(1);

        // Exact fit, stall, same-cycle return (R4 R5)
        launch(6, 1024, 1024);
        until_issued();
        step(4);
        @(negedge clk);
        chk(disp_valid == 0, "R4 stalled when full", disp_valid, 0);
        step(1);
        cmpl_pulse = 4'b0100;
        @(negedge clk);
        chk(disp_valid == 1, "R5 same-cycle reuse valid", disp_valid, 1);
        chk(disp_unit == 2, "R5 same-cycle reuse unit", disp_unit, 2);
        step(1);
        cmpl_pulse = '0;
        disp_ready = 1'b0;
        pulse(1);
        @(negedge clk);
        held_idx = disp_index;
        step(3);
        @(negedge clk);
        chk(disp_valid == 1 && disp_index == held_idx, "R2 offer held", disp_index, held_idx);
        step(1);
        disp_ready = 1'b1;
        step(2);
        pulse(0); pulse(1); pulse(2); pulse(3);
        until_done();
        step(1);

        // Zero-count grid (R8)
        launch(0, 1, 1);
        @(negedge clk);
        chk(grid_done == 1, "R8 zero grid done", grid_done, 1);
        step(1);

        // Launch while busy is ignored (R1)
        disp_ready = 1'b0;
        launch(2, 1024, 1024);
        launch_valid = 1'b1; launch_count = CW'(9);
        step(1);
        launch_valid = 1'b0;
        @(negedge clk);
        chk(launch_ready == 0, "R1 busy not ready", launch_ready, 0);
        step(1);
        disp_ready = 1'b1;
        until_issued();
        step(1);
        pulse(0); pulse(1);
        until_done();
        @(negedge clk);
        chk(grid_done == 1, "R8 final done", grid_done, 1);
        chk(exp_q.size() == 0, "R2 all blocks seen", exp_q.size(), 0);
        step(2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule